// File: doc/BRIEF.md
# LED Driver Fault-Detection Mode Controller

This block sits beside the serial shift path of a 16-channel constant-current LED sink driver. It decides whether the driver is in ordinary display operation or in one of two load-fault detection modes. The mode is not set by a register write. It is chosen by a clocked pattern on the output-enable and latch pins, which the block samples at successive rising edges of the serial clock. The block watches those pins, the serial clock and a per-channel comparator result vector. All of these inputs are treated as synchronous to a free-running system clock `clk`.

In a detection mode, pulling the active-low output enable low starts a measurement window. The block counts serial-clock rising edges inside that window and times the window against the system clock. On the first qualifying edge it raises a one-cycle capture strobe and copies the comparator vector into `cap_word`. The neighbouring shift register loads this value in parallel, with priority over a shift, and later sends it out most-significant bit first. A comparator bit of 0 marks a faulty channel: an open load at or below about 0.3 V, or a shorted load at or above about 3.0 V. A bit of 1 marks a healthy channel. The block also tells the neighbouring logic when to ignore serial input and when a latch pulse belongs to a mode command rather than to display data.

Top module: `led_fault_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0, `cap_strobe` is 0, `cap_word` is all zeros and `latch_block` is 0. `sin_block` is 0 while `oe_n` is 1.
- R2: Five consecutive sampled `sck` rising edges form a mode command when `oe_n` is 1, 0, 1, 1, 1 and `slat` is 0 in the first three of them. The `slat` levels at the fourth and fifth edges choose the mode: (1,0) gives short-detect (`mode`=2), (0,1) gives open-detect (`mode`=1) and (0,0) gives normal (`mode`=0). `mode` takes its new value in the clock cycle after the fifth edge is sampled.
- R3: Any other `oe_n`/`slat` combination over those edges leaves `mode` unchanged, including `slat` high at both the fourth and fifth edges.
- R4: `latch_block` is 1 from the cycle after the second matching edge of a command until the command completes or breaks. If `slat` is high at completion, it stays 1 until `slat` is seen low. While `oe_n` is held at 1 during ordinary shifting, `latch_block` stays 0 even when `slat` pulses.
- R5: `sin_block` is 1 exactly when `mode` is nonzero and `oe_n` is 0.
- R6: In a detection mode, call the clock edge that first samples `oe_n` low edge 0. `cap_strobe` pulses for one cycle after the first `sck` rising edge that is the third or a later rise after edge 0 and is sampled at least MIN_WAIT_CYC+1 clock edges after edge 0. There is at most one pulse for each low period of `oe_n`.
- R7: `cap_word` takes the value of `chan_ok` on the edge that raises `cap_strobe`, and otherwise holds its value.
- R8: No capture occurs in normal mode. No capture occurs if `oe_n` returns to 1 before a qualifying edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck | input | 1 | Serial clock level |
| slat | input | 1 | Latch pin level |
| oe_n | input | 1 | Active-low output enable level |
| chan_ok | input | CH | Per-channel comparator result, 1 = healthy |
| mode | output | 2 | 0 normal, 1 open-detect, 2 short-detect |
| cap_strobe | output | 1 | One-cycle parallel-load request to the shift register |
| cap_word | output | CH | Comparator vector taken at capture |
| latch_block | output | 1 | Suppresses the output latch during a mode command |
| sin_block | output | 1 | Serial input must be ignored |

## Verification
The bench builds the block with CH=16 and MIN_WAIT_CYC=6. This short window lets the third serial edge land both before and after the timer expires, depending on edge spacing. It sweeps all 1024 combinations of five `oe_n`/`slat` slot pairs against a pattern model, so every partial, broken and conflicting command is covered. It then sweeps start offsets and edge spacings of the detect window, and in each case compares the strobe cycle by cycle with an arithmetically predicted capture edge.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_OPEN   = 2'd1,
    MODE_SHORT  = 2'd2
  } det_mode_e;

  // command pattern geometry (slot index = order of sck rises)
  localparam int PAT_LEN     = 5;
  localparam int OE_LOW_SLOT = 1;   // the only slot with oe_n low
  localparam int PICK_A_SLOT = 3;   // slat here alone -> short detect
  localparam int COMMIT_SLOT = 2;   // slots matched before latch is held off
  localparam int CAP_EDGE    = 3;   // ordinal of first usable sck rise
endpackage

// File: rtl/fd_pin_edge.sv
module fd_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic oe_n,
  output logic sck_rise,
  output logic oe_fall
);
  logic sck_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      oe_q  <= oe_n;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign oe_fall  = oe_q & ~oe_n;
endmodule

// File: rtl/fd_mode_match.sv
module fd_mode_match
  import fd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_rise,
  input  logic      oe_n,
  input  logic      slat,
  output det_mode_e mode_o,
  output logic      latch_block_o
);
  localparam int SW = $clog2(PAT_LEN);

  logic [SW-1:0] slot_q, slot_d;
  logic          pick_q, pick_d;
  logic          hold_q, hold_d;
  det_mode_e     mode_q, mode_d;
  logic          exp_oe, slat_ok, hit;

  always_comb begin
    slot_d  = slot_q;
    pick_d  = pick_q;
    hold_d  = hold_q;
    mode_d  = mode_q;
    exp_oe  = (slot_q != SW'(OE_LOW_SLOT));
    slat_ok = (slot_q < SW'(PICK_A_SLOT)) ? !slat : 1'b1;
    hit     = (oe_n == exp_oe) && slat_ok;
    if (!slat) hold_d = 1'b0;
    if (sck_rise) begin
      if (hit) begin
        if (slot_q == SW'(PAT_LEN - 1)) begin
          slot_d = '0;
          pick_d = 1'b0;
          hold_d = slat;
          if (!(pick_q && slat))
            mode_d = pick_q ? MODE_SHORT : (slat ? MODE_OPEN : MODE_NORMAL);
        end else begin
          slot_d = slot_q + 1'b1;
          if (slot_q == SW'(PICK_A_SLOT)) pick_d = slat;
        end
      end else begin
        // restart: this edge may itself open a new command
        slot_d = (oe_n && !slat) ? SW'(1) : '0;
        pick_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pick_q <= 1'b0;
      hold_q <= 1'b0;
      mode_q <= MODE_NORMAL;
    end else begin
      slot_q <= slot_d;
      pick_q <= pick_d;
      hold_q <= hold_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o        = mode_q;
  assign latch_block_o = (slot_q >= SW'(COMMIT_SLOT)) || hold_q;
endmodule

// File: rtl/fd_capture.sv
module fd_capture
  import fd_pkg::*;
#(
  parameter int CH       = 16,
  parameter int MIN_WAIT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_en,
  input  logic          oe_n,
  input  logic          oe_fall,
  input  logic          sck_rise,
  input  logic [CH-1:0] status,
  output logic          strobe_o,
  output logic [CH-1:0] word_o
);
  localparam int TW = $clog2(MIN_WAIT + 1);
  localparam int EW = $clog2(CAP_EDGE + 1);

  logic          armed_q, armed_d;
  logic          done_q, done_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          stb_q, stb_d;
  logic [CH-1:0] word_q, word_d;
  logic          tmr_full;

  always_comb begin
    armed_d  = armed_q;
    done_d   = done_q;
    ecnt_d   = ecnt_q;
    tmr_d    = tmr_q;
    word_d   = word_q;
    stb_d    = 1'b0;
    tmr_full = (tmr_q == TW'(MIN_WAIT));
    if (oe_n) begin
      armed_d = 1'b0;
    end else if (oe_fall && det_en) begin
      armed_d = 1'b1;
      done_d  = 1'b0;
      ecnt_d  = '0;
      tmr_d   = '0;
    end else if (armed_q) begin
      if (!tmr_full) tmr_d = tmr_q + 1'b1;
      if (sck_rise) begin
        if (ecnt_q != EW'(CAP_EDGE)) ecnt_d = ecnt_q + 1'b1;
        if ((ecnt_q >= EW'(CAP_EDGE - 1)) && tmr_full && !done_q) begin
          stb_d  = 1'b1;
          word_d = status;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      ecnt_q  <= '0;
      tmr_q   <= '0;
      stb_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      armed_q <= armed_d;
      done_q  <= done_d;
      ecnt_q  <= ecnt_d;
      tmr_q   <= tmr_d;
      stb_q   <= stb_d;
      word_q  <= word_d;
    end
  end

  assign strobe_o = stb_q;
  assign word_o   = word_q;
endmodule

// File: rtl/led_fault_mode_ctrl.sv
module led_fault_mode_ctrl
  import fd_pkg::*;
#(
  parameter int CH           = 16,
  parameter int MIN_WAIT_CYC = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          slat,
  input  logic          oe_n,
  input  logic [CH-1:0] chan_ok,
  output logic [1:0]    mode,
  output logic          cap_strobe,
  output logic [CH-1:0] cap_word,
  output logic          latch_block,
  output logic          sin_block
);
  logic      rst_s1, srst_n;
  logic      sck_rise, oe_fall;
  det_mode_e cur_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      srst_n <= rst_s1;
    end
  end

  fd_pin_edge u_edge (
    .clk(clk), .rst_n(srst_n), .sck(sck), .oe_n(oe_n),
    .sck_rise(sck_rise), .oe_fall(oe_fall)
  );

  fd_mode_match u_match (
    .clk(clk), .rst_n(srst_n), .sck_rise(sck_rise), .oe_n(oe_n),
    .slat(slat), .mode_o(cur_mode), .latch_block_o(latch_block)
  );

  fd_capture #(.CH(CH), .MIN_WAIT(MIN_WAIT_CYC)) u_cap (
    .clk(clk), .rst_n(srst_n), .det_en(cur_mode != MODE_NORMAL),
    .oe_n(oe_n), .oe_fall(oe_fall), .sck_rise(sck_rise),
    .status(chan_ok), .strobe_o(cap_strobe), .word_o(cap_word)
  );

  assign mode      = cur_mode;
  assign sin_block = (cur_mode != MODE_NORMAL) && !oe_n;
endmodule

// File: rtl/fd_ctrl_checker.sv
module fd_ctrl_checker #(
  parameter int CH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          oe_n,
  input logic [1:0]    mode,
  input logic          cap_strobe,
  input logic [CH-1:0] cap_word,
  input logic          sin_block
);
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);

  assert_strobe_oe_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> !$past(oe_n));

  assert_strobe_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> ($past(mode) != 2'd0));

  assert_strobe_sin_blk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> $past(sin_block));

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |-> $stable(cap_word));

  assert_mode_on_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> ($past(sck) && $past(oe_n)));
endmodule

bind led_fault_mode_ctrl fd_ctrl_checker #(.CH(CH)) i_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .oe_n(oe_n), .mode(mode),
  .cap_strobe(cap_strobe), .cap_word(cap_word), .sin_block(sin_block)
);

// File: tb/test_led_fault_mode_ctrl.sv
module test_led_fault_mode_ctrl;
  localparam int CLK_NS = 10;
  localparam int CH     = 16;
  localparam int MINW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, slat = 1'b0, oe_n = 1'b1;
  logic [CH-1:0] chan_ok = '0;
  logic [1:0]    mode;
  logic          cap_strobe, latch_block, sin_block;
  logic [CH-1:0] cap_word;

  int errs = 0, checks = 0;
  bit fin = 1'b0;
  logic [1:0]    exp_mode = 2'd0;
  logic [CH-1:0] exp_word = '0;

  always #(CLK_NS/2) clk = ~clk;

  led_fault_mode_ctrl #(.CH(CH), .MIN_WAIT_CYC(MINW)) i_led_fault_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .slat(slat), .oe_n(oe_n),
    .chan_ok(chan_ok), .mode(mode), .cap_strobe(cap_strobe),
    .cap_word(cap_word), .latch_block(latch_block), .sin_block(sin_block)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic slot(input bit o, input bit s);
    @(negedge clk); oe_n = o; slat = s; sck = 1'b0;
    @(negedge clk); sck = 1'b1;
  endtask

  // bit i of o/s is the level at the i-th sck rise; ends one cycle after the last rise
  task automatic pat(input logic [4:0] o, input logic [4:0] s);
    for (int i = 0; i < 5; i++) slot(o[i], s[i]);
    @(negedge clk); sck = 1'b0;
  endtask

  function automatic logic [1:0] model(input logic [4:0] o, input logic [4:0] s,
                                       input logic [1:0] prev);
    if (o != 5'b11101 || s[2:0] != 3'b000) return prev;
    if (s[3] && !s[4]) return 2'd2;
    if (!s[3] && s[4]) return 2'd1;
    if (!s[3] && !s[4]) return 2'd0;
    return prev;
  endfunction

  task automatic flush();
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    flush();
    pat(5'b11101, {m == 2'd1, m == 2'd2, 3'b000});
    slat = 1'b0;
    exp_mode = m;
    chk(mode == m, "R2", mode, m);
  endtask

  // detect window: oe low, sck rises at a, a+g, ... (six rises)
  task automatic cap_run(input int a, input int g, input bit det, input logic [CH-1:0] val);
    int capj, nth, last;
    capj = -1; nth = 0;
    for (int r = 0; r < 6; r++) begin
      nth++;
      if (capj < 0 && det && nth >= 3 && (a + r*g) >= MINW + 1) capj = a + r*g;
    end
    last = a + 5*g + 2;
    chan_ok = val;
    @(negedge clk); oe_n = 1'b0; sck = 1'b0; slat = 1'b0;
    for (int j = 1; j <= last; j++) begin
      @(negedge clk);
      chk(cap_strobe == (j - 1 == capj), "R6 strobe timing", cap_strobe, (j - 1 == capj));
      chk(sin_block == det, "R5 sin_block", sin_block, det);
      sck = (j >= a) && ((j - a) % g == 0) && ((j - a) / g < 6);
    end
    @(negedge clk); sck = 1'b0;
    if (capj >= 0) exp_word = val;
    chk(cap_word == exp_word, "R7 cap_word", cap_word, exp_word);
    oe_n = 1'b1;
    #1 chk(sin_block == 1'b0, "R5 oe high", sin_block, 0);
    @(negedge clk);
    chk(cap_strobe == 1'b0, "R6 after window", cap_strobe, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(cap_strobe == 1'b0, "R1 strobe", cap_strobe, 0);
    chk(cap_word == '0, "R1 word", cap_word, 0);
    chk(latch_block == 1'b0, "R1 latch_block", latch_block, 0);
    chk(sin_block == 1'b0, "R1 sin_block", sin_block, 0);

    // R2 / R3: every five-slot oe_n/slat combination
    for (int c = 0; c < 1024; c++) begin
      logic [4:0] o, s;
      logic [1:0] nm;
      o = c[4:0]; s = c[9:5];
      flush();
      nm = model(o, s, exp_mode);
      pat(o, s);
      slat = 1'b0;
      chk(mode == nm, (nm != exp_mode) ? "R2 mode command" : "R3 mode unchanged", mode, nm);
      exp_mode = nm;
    end

    // R4: ordinary shifting with a latch pulse
    set_mode(2'd0);
    slot(1'b1, 1'b0); slot(1'b1, 1'b0); slot(1'b1, 1'b0);
    @(negedge clk); sck = 1'b0; slat = 1'b1;
    @(negedge clk);
    chk(latch_block == 1'b0, "R4 shift latch", latch_block, 0);
    slat = 1'b0;

    // R4: short command, latch pulse inside slot 4
    flush();
    slot(1'b1, 1'b0);
    @(negedge clk);
    chk(latch_block == 1'b0, "R4 one slot", latch_block, 0);
    sck = 1'b0; oe_n = 1'b0;
    @(negedge clk); sck = 1'b1;
    slot(1'b1, 1'b0);
    @(negedge clk); oe_n = 1'b1; slat = 1'b1; sck = 1'b0;
    #1 chk(latch_block == 1'b1, "R4 slot4 block", latch_block, 1);
    @(negedge clk); sck = 1'b1;
    @(negedge clk); sck = 1'b0; slat = 1'b0;
    #1 chk(latch_block == 1'b1, "R4 slot5 block", latch_block, 1);
    @(negedge clk); sck = 1'b1;
    @(negedge clk); sck = 1'b0;
    chk(mode == 2'd2, "R2 short", mode, 2);
    chk(latch_block == 1'b0, "R4 released", latch_block, 0);
    exp_mode = 2'd2;

    // R4: open command ends with slat high -> held until slat low
    flush();
    pat(5'b11101, 5'b10000);
    chk(mode == 2'd1, "R2 open", mode, 1);
    chk(latch_block == 1'b1, "R4 hold", latch_block, 1);
    @(negedge clk);
    chk(latch_block == 1'b1, "R4 hold kept", latch_block, 1);
    slat = 1'b0;
    @(negedge clk);
    chk(latch_block == 1'b0, "R4 hold cleared", latch_block, 0);
    exp_mode = 2'd1;

    // R6 / R7: sweep of first-edge offset and edge spacing, both detect modes
    for (int m = 1; m <= 2; m++) begin
      set_mode(m[1:0]);
      for (int a = 1; a <= 3; a++)
        for (int g = 2; g <= 5; g++)
          cap_run(a, g, 1'b1, CH'((a * 16'h1357) ^ (g * 16'h2468) ^ (m * 16'h8001)));
    end

    // R8: normal mode never captures and never blocks serial input
    set_mode(2'd0);
    cap_run(1, 2, 1'b0, 16'h0F0F);
    cap_run(2, 5, 1'b0, 16'hF00F);

    // R8: window closed before a qualifying edge
    set_mode(2'd2);
    chan_ok = 16'hBEEF;
    @(negedge clk); oe_n = 1'b0; sck = 1'b0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      chk(cap_strobe == 1'b0, "R8 abort", cap_strobe, 0);
      sck = (j % 2 == 1);
      if (j == 5) oe_n = 1'b1;
    end
    @(negedge clk); sck = 1'b0;
    chk(cap_word == exp_word, "R8 word kept", cap_word, exp_word);
    chk(mode == 2'd2, "R3 mode kept", mode, 2);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule